// File: doc/BRIEF.md
# Integer Arithmetic-Logic Execution Unit

This block computes one integer operation per accepted request on 32-bit operands. A caller presents an operation code, two register operands, a 16-bit immediate field and a 5-bit shift count. The arithmetic group covers add, subtract and add-with-immediate. The bitwise group covers AND, OR, NOR and XOR, together with immediate versions of AND, OR and XOR. Logical shifts go left or right, and a load-upper operation places the immediate in the high half of the word. Immediate extension happens inside the block. Add-with-immediate uses a sign-extended immediate. The bitwise immediates use the 16 bits as a raw pattern with zero upper bits.

The arithmetic and logic are purely combinational. They sit behind one output register stage with a valid flag. A request is taken in any cycle in which `in_valid` is high. Its result and illegal-code flag appear on the outputs one clock later, qualified by `out_valid`. In cycles without a request, the outputs keep their last values. Arithmetic wraps modulo 2^32 and no overflow is reported. An operation code outside the supported set yields a zero result with the illegal flag set.

Top module: `intalu_exec`

## Requirements
- R1: Codes 0 (add), 1 (subtract) and 8 (add immediate) produce results modulo 2^32 with no trap; subtract returns `src_a - src_b`.
- R2: Code 8 adds `src_a` to `imm16` sign-extended to 32 bits, so an immediate with bit 15 set acts as a negative value.
- R3: Codes 9, 10 and 11 apply AND, OR and XOR between `src_a` and `imm16` zero-extended to 32 bits. AND-immediate therefore clears bits 31:16, and OR/XOR-immediate pass bits 31:16 of `src_a` through.
- R4: Code 6 shifts `src_a` left and code 7 shifts `src_a` right, each by `shamt` (0 to 31) positions, with zeros filling the vacated bits. There is no sign fill on a right shift.
- R5: Code 12 returns `imm16` in bits 31:16 with bits 15:0 zero.
- R6: Codes 2, 3, 4 and 5 apply bitwise AND, OR, NOR and XOR between `src_a` and `src_b`. NOR with a zero operand gives the complement, and so does XOR with an all-ones operand.
- R7: Codes 13 to 15 produce a zero result with `op_illegal` high. Every supported code drives `op_illegal` low.
- R8: `out_valid` is high in the cycle after a clock edge where `in_valid` was high, and low after an edge where it was low. `result` and `op_illegal` belong to that accepted request.
- R9: Asserting `rst_n` low clears `out_valid`, `result` and `op_illegal` without waiting for a clock edge.
- R10: At a clock edge where `in_valid` is low, `result` and `op_illegal` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous to `clk` |
| in_valid | input | 1 | A request is present this cycle |
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First register operand; also the shift source |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Shift count |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result |
| op_illegal | output | 1 | Registered flag: the operation code was unsupported |

## Verification
The hardest case to reach from the ports is the hold behaviour. The outputs must stay frozen while every data input changes and `in_valid` stays low. A bench that always drives requests back to back never exercises it. The directed part of the bench therefore first lets a known result settle. It then drops `in_valid` and drives a different code with new operands, shift count and immediate, and confirms that neither `result` nor `op_illegal` moves. It also pulls reset low between clock edges in the middle of a stream, to show that the outputs clear at once.

// File: rtl/intalu_pkg.sv
`timescale 1ns/1ps
package intalu_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int SH_W  = $clog2(XLEN);
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_XOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_ADDI = 4'd8,
    OP_ANDI = 4'd9,
    OP_ORI  = 4'd10,
    OP_XORI = 4'd11,
    OP_LUI  = 4'd12
  } op_e;
endpackage

// File: rtl/intalu_immext.sv
`timescale 1ns/1ps
module intalu_immext #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  imm_sext,
  output logic [XLEN-1:0]  imm_zext,
  output logic [XLEN-1:0]  imm_upper
);
  localparam int PAD_W = XLEN - IMM_W;

  assign imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_zext  = {{PAD_W{1'b0}}, imm};
  assign imm_upper = {imm, {PAD_W{1'b0}}};
endmodule

// File: rtl/intalu_shift.sv
`timescale 1ns/1ps
module intalu_shift #(
  parameter int WIDTH = 32,
  parameter bit LEFT  = 1'b1,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [AMT_W+1];

  assign stage[0] = din;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    if (LEFT) begin : g_left
      assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
    end else begin : g_right
      assign stage[i+1] = amt[i] ? (stage[i] >> (1 << i)) : stage[i];
    end
  end

  assign dout = stage[AMT_W];
endmodule

// File: rtl/intalu_core.sv
`timescale 1ns/1ps
module intalu_core
  import intalu_pkg::*;
#(
  parameter int XLEN  = intalu_pkg::XLEN,
  parameter int IMM_W = intalu_pkg::IMM_W,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [OP_W-1:0]  op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt,
  output logic [XLEN-1:0]  res,
  output logic             bad_op
);
  logic [XLEN-1:0] imm_sext, imm_zext, imm_upper;
  logic [XLEN-1:0] shl, shr;
  logic [XLEN-1:0] add_rhs, logic_rhs, sum;
  logic            is_imm_logic;

  intalu_immext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_immext (
    .imm      (imm),
    .imm_sext (imm_sext),
    .imm_zext (imm_zext),
    .imm_upper(imm_upper)
  );

  intalu_shift #(.WIDTH(XLEN), .LEFT(1'b1)) u_shl (
    .din(a), .amt(shamt), .dout(shl)
  );

  intalu_shift #(.WIDTH(XLEN), .LEFT(1'b0)) u_shr (
    .din(a), .amt(shamt), .dout(shr)
  );

  // one shared adder: subtract is a + ~b + 1
  always_comb begin
    if (op == OP_SUB)       add_rhs = ~b;
    else if (op == OP_ADDI) add_rhs = imm_sext;
    else                    add_rhs = b;
    sum = a + add_rhs + XLEN'(op == OP_SUB);
  end

  assign is_imm_logic = (op == OP_ANDI) || (op == OP_ORI) || (op == OP_XORI);
  assign logic_rhs    = is_imm_logic ? imm_zext : b;

  always_comb begin
    res    = '0;
    bad_op = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_ADDI: res = sum;
      OP_AND, OP_ANDI:         res = a & logic_rhs;
      OP_OR, OP_ORI:           res = a | logic_rhs;
      OP_NOR:                  res = ~(a | logic_rhs);
      OP_XOR, OP_XORI:         res = a ^ logic_rhs;
      OP_SLL:                  res = shl;
      OP_SRL:                  res = shr;
      OP_LUI:                  res = imm_upper;
      default:                 bad_op = 1'b1;
    endcase
  end

  always_comb begin
    if (op == OP_LUI) begin
      p_lui_low_zero_r5: assert (res[IMM_W-1:0] == '0);
    end
    if (op == OP_SRL && shamt != '0) begin
      p_srl_zero_fill_r4: assert (res[XLEN-1] == 1'b0);
    end
    if (op == OP_SLL && shamt != '0) begin
      p_sll_zero_fill_r4: assert (res[0] == 1'b0);
    end
    if (op == OP_ANDI) begin
      p_andi_upper_clear_r3: assert (res[XLEN-1:IMM_W] == '0);
    end
  end
endmodule

// File: rtl/intalu_exec.sv
`timescale 1ns/1ps
module intalu_exec
  import intalu_pkg::*;
#(
  parameter int XLEN  = intalu_pkg::XLEN,
  parameter int IMM_W = intalu_pkg::IMM_W,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [SH_W-1:0]  shamt,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             op_illegal
);
  logic [XLEN-1:0] core_res;
  logic            core_bad;
  logic [XLEN-1:0] res_d, res_q;
  logic            bad_d, bad_q;
  logic            vld_d, vld_q;

  intalu_core #(.XLEN(XLEN), .IMM_W(IMM_W)) u_core (
    .op    (op_sel),
    .a     (src_a),
    .b     (src_b),
    .imm   (imm16),
    .shamt (shamt),
    .res   (core_res),
    .bad_op(core_bad)
  );

  // next state: clock enable on in_valid for the data registers
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    bad_d = bad_q;
    if (in_valid) begin
      res_d = core_res;
      bad_d = core_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      bad_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      bad_q <= bad_d;
    end
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign op_illegal = bad_q;

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(op_illegal)));
  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_illegal |-> (result == '0));
  p_legal_flag_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel <= OP_W'(OP_LUI)) |=> !op_illegal);
endmodule

// File: tb/intalu_exec_tb.sv
`timescale 1ns/1ps
module intalu_exec_tb_top;
  localparam int NV = 23;
  // fields: op[121:118] a[117:86] b[85:54] imm[53:38] sh[37:33] exp[32:1] ill[0]
  localparam logic [121:0] VEC [NV] = '{
    {4'd0,  32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'h0000000C, 1'b0}, // R1 add
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000, 1'b0}, // R1 wrap
    {4'd1,  32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'hFFFFFFFE, 1'b0}, // R1 sub order
    {4'd1,  32'h00000007, 32'h00000005, 16'h0000, 5'd0,  32'h00000002, 1'b0}, // R1
    {4'd8,  32'h00000010, 32'h12345678, 16'hFFFF, 5'd0,  32'h0000000F, 1'b0}, // R2 -1
    {4'd8,  32'h00000000, 32'h00000000, 16'h8000, 5'd0,  32'hFFFF8000, 1'b0}, // R2 min
    {4'd8,  32'h7FFFFFFF, 32'h00000000, 16'h0001, 5'd0,  32'h80000000, 1'b0}, // R1 no trap
    {4'd9,  32'hFFFFFFFF, 32'h00000000, 16'h0FFF, 5'd0,  32'h00000FFF, 1'b0}, // R3 andi
    {4'd10, 32'hAAAA0000, 32'h00000000, 16'hF0F0, 5'd0,  32'hAAAAF0F0, 1'b0}, // R3 ori
    {4'd11, 32'h12345678, 32'h00000000, 16'hFFFF, 5'd0,  32'h1234A987, 1'b0}, // R3 xori
    {4'd6,  32'h0000000F, 32'hFFFFFFFF, 16'hFFFF, 5'd4,  32'h000000F0, 1'b0}, // R4 sll
    {4'd6,  32'h80000001, 32'h00000000, 16'h0000, 5'd31, 32'h80000000, 1'b0}, // R4 sll 31
    {4'd7,  32'h80000000, 32'h00000000, 16'h0000, 5'd31, 32'h00000001, 1'b0}, // R4 srl 31
    {4'd7,  32'hF0000000, 32'h00000000, 16'h0000, 5'd4,  32'h0F000000, 1'b0}, // R4 no sign fill
    {4'd6,  32'h12345678, 32'h00000000, 16'h0000, 5'd0,  32'h12345678, 1'b0}, // R4 zero shift
    {4'd12, 32'h00001234, 32'h55555555, 16'hAAAA, 5'd7,  32'hAAAA0000, 1'b0}, // R5 lui
    {4'd2,  32'hFF00FF00, 32'h0FF00FF0, 16'hFFFF, 5'd0,  32'h0F000F00, 1'b0}, // R6 and
    {4'd3,  32'hFF00FF00, 32'h0FF00FF0, 16'h0000, 5'd0,  32'hFFF0FFF0, 1'b0}, // R6 or
    {4'd4,  32'hF0F0F0F0, 32'h0F0F0000, 16'h0000, 5'd0,  32'h00000F0F, 1'b0}, // R6 nor
    {4'd4,  32'h12345678, 32'h00000000, 16'h0000, 5'd0,  32'hEDCBA987, 1'b0}, // R6 nor not
    {4'd5,  32'h12345678, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'hEDCBA987, 1'b0}, // R6 xor not
    {4'd13, 32'h00000005, 32'h00000007, 16'h1234, 5'd3,  32'h00000000, 1'b1}, // R7
    {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31, 32'h00000000, 1'b1}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [31:0] result;
  logic        op_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intalu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
    .out_valid(out_valid), .result(result), .op_illegal(op_illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0;
    src_a = '0; src_b = '0; imm16 = '0; shamt = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset result", result, 32'd0);
    chk("R9 reset op_illegal", 32'(op_illegal), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back vector stream
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      op_sel = VEC[i][121:118];
      src_a  = VEC[i][117:86];
      src_b  = VEC[i][85:54];
      imm16  = VEC[i][53:38];
      shamt  = VEC[i][37:33];
      @(negedge clk);
      chk($sformatf("R8 vec%0d out_valid", i), 32'(out_valid), 32'd1);
      chk($sformatf("R1-6 vec%0d result", i), result, VEC[i][32:1]);
      chk($sformatf("R7 vec%0d op_illegal", i), 32'(op_illegal), 32'(VEC[i][0]));
    end

    // R10: hold a legal result while all inputs change, in_valid low
    in_valid = 1'b1; op_sel = 4'd0; src_a = 32'h00000100; src_b = 32'h00000023;
    @(negedge clk);
    chk("R1 pre-hold add", result, 32'h00000123);
    in_valid = 1'b0; op_sel = 4'd14; src_a = 32'hDEADBEEF; src_b = 32'h0BADF00D;
    imm16 = 16'h5A5A; shamt = 5'd9;
    @(negedge clk);
    chk("R8 idle out_valid low", 32'(out_valid), 32'd0);
    chk("R10 hold result", result, 32'h00000123);
    chk("R10 hold op_illegal", 32'(op_illegal), 32'd0);
    op_sel = 4'd12;
    @(negedge clk);
    chk("R10 hold result second idle", result, 32'h00000123);

    // R10: hold an illegal flag while idle
    in_valid = 1'b1; op_sel = 4'd14;
    @(negedge clk);
    chk("R7 code 14 flag", 32'(op_illegal), 32'd1);
    in_valid = 1'b0; op_sel = 4'd0;
    @(negedge clk);
    chk("R10 hold illegal flag", 32'(op_illegal), 32'd1);

    // R9: asynchronous reset in the middle of a stream
    in_valid = 1'b1; op_sel = 4'd3; src_a = 32'h0000F000; src_b = 32'h0000000F;
    @(negedge clk);
    chk("R6 or before reset", result, 32'h0000F00F);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R9 async clear out_valid", 32'(out_valid), 32'd0);
    chk("R9 async clear result", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 valid after reset release", 32'(out_valid), 32'd1);
    chk("R6 result after reset release", result, 32'h0000F00F);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule